// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the memory traffic a processor core needs when it takes an interrupt and when it later returns from one. When it is started with an 8-bit vector number, it saves the caller's context on the stack: the flags word, then the code segment, then the return instruction pointer. It then reads the four-byte handler address for that vector from a table at physical address zero and presents the new instruction pointer, code segment, flags and stack pointer. The flags it presents have the interrupt-enable and trap bits cleared. The return strobe runs the reverse: it pops the instruction pointer, the code segment and the flags word, and restores all of them unchanged.

All traffic goes one byte at a time over a single memory port. Physical addresses are 20 bits wide and are formed as segment × 16 + offset, wrapping modulo 2^20. Each byte waits for a ready handshake, so slow memory simply stretches the sequence. The surrounding core decodes instructions, decides when to start a sequence, and consumes the new register values on the done pulse.

Top module: `intr_seq`

## Requirements
- R1: While reset is asserted and after it is released, mem_req_o, mem_we_o and done_o are 0, and new_ip_o, new_cs_o, new_flags_o and new_sp_o are 0.
- R2: On start_i the block performs exactly six byte writes, in this order: flags high, flags low, CS high, CS low, IP high, IP low. Before each write the working SP is decremented by one, and the byte is written to SS×16+SP. As a result, the lower byte of each word sits at the lower address.
- R3: After the six pushes, the block reads four bytes at vector×4+0 through vector×4+3. These are, in order, IP low, IP high, CS low and CS high. new_ip_o and new_cs_o are taken from these bytes.
- R4: After an entry, new_flags_o equals the saved flags with bit 9 (interrupt enable) and bit 8 (trap) cleared and all other bits unchanged, and new_sp_o equals the entry SP minus 6 (mod 2^16).
- R5: On iret_i the block reads six bytes at SS×16+SP, incrementing SP after each read. The bytes are, in order, IP low, IP high, CS low, CS high, flags low and flags high. new_ip_o, new_cs_o and new_flags_o (including bits 9 and 8) take the popped values, and new_sp_o equals the return SP plus 6.
- R6: While mem_req_o is high and mem_rdy_i is low, mem_addr_o, mem_we_o and mem_wdata_o hold their values. Each cycle in which mem_req_o and mem_rdy_i are both high completes exactly one byte.
- R7: done_o is a single-cycle pulse, raised two cycles after the final byte completes. The new register outputs are valid while it is high and hold until the next sequence.
- R8: A start_i or iret_i that arrives while a sequence is running is ignored: it neither alters the running sequence nor causes any additional memory access or done pulse.
- R9: Physical addresses wrap modulo 2^20, and the stack pointer wraps modulo 2^16, during both pushes and pops.
- R10: If start_i and iret_i are both high in the same idle cycle, the entry sequence runs and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin interrupt entry |
| vec_i | input | 8 | Vector number for entry |
| iret_i | input | 1 | Begin interrupt return |
| cur_ip_i | input | 16 | Return instruction pointer |
| cur_cs_i | input | 16 | Current code segment |
| cur_flags_i | input | 16 | Current flags word |
| cur_sp_i | input | 16 | Current stack pointer |
| cur_ss_i | input | 16 | Current stack segment |
| new_ip_o | output | 16 | Instruction pointer after the sequence |
| new_cs_o | output | 16 | Code segment after the sequence |
| new_flags_o | output | 16 | Flags after the sequence |
| new_sp_o | output | 16 | Stack pointer after the sequence |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Byte access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| mem_rdy_i | input | 1 | Access completes this cycle |

## Verification
Some properties are checked on every cycle. The request, address and write data must stay stable while ready is low. Writes may appear only during entry. done must be a single pulse that follows a completed access. Flags presented after an entry must have the enable and trap bits clear. A strobe arriving mid-sequence must not change the mode.

Other properties need the bench's scenarios. These include the exact byte order and addresses of the pushes and pops, the handler fetch from vector×4, and the full round trip that restores IP, CS, flags and SP. The same applies to segment and pointer wrap-around, and to priority and ignore behaviour under colliding strobes.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PUSH = 3'd1,
    ST_VEC  = 3'd2,
    ST_POP  = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_t;

  localparam int PUSH_BYTES = 6;
  localparam int VEC_BYTES  = 4;
  localparam int POP_BYTES  = 6;
endpackage

// File: rtl/intr_seq_phys.sv
module intr_seq_phys #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [SEG_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o
);
  always_comb begin
    phys_o = (ADDR_W'(seg_i) << SHIFT) + ADDR_W'(off_i);
  end
endmodule

// File: rtl/intr_seq_lane.sv
module intr_seq_lane #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 2 * BYTE_W,
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  output logic [BYTE_W-1:0] byte_o
);
  always_comb begin
    unique case (step_i)
      STEP_W'(0): byte_o = flags_i[BYTE_W +: BYTE_W];
      STEP_W'(1): byte_o = flags_i[0 +: BYTE_W];
      STEP_W'(2): byte_o = cs_i[BYTE_W +: BYTE_W];
      STEP_W'(3): byte_o = cs_i[0 +: BYTE_W];
      STEP_W'(4): byte_o = ip_i[BYTE_W +: BYTE_W];
      default:    byte_o = ip_i[0 +: BYTE_W];
    endcase
  end
endmodule

// File: rtl/intr_seq_gather.sv
module intr_seq_gather #(
  parameter int SLOTS  = 6,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [BYTE_W-1:0]            d_i,
  output logic [SLOTS-1:0][BYTE_W-1:0] slots_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slots_o[g] <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        slots_o[g] <= d_i;
      end
    end
  end
endmodule

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter int BYTE_W    = 8,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int VEC_W     = 8,
  parameter int SEG_SHIFT = 4,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              iret_i,
  input  logic [WORD_W-1:0] cur_ip_i,
  input  logic [WORD_W-1:0] cur_cs_i,
  input  logic [WORD_W-1:0] cur_flags_i,
  input  logic [WORD_W-1:0] cur_sp_i,
  input  logic [WORD_W-1:0] cur_ss_i,
  output logic [WORD_W-1:0] new_ip_o,
  output logic [WORD_W-1:0] new_cs_o,
  output logic [WORD_W-1:0] new_flags_o,
  output logic [WORD_W-1:0] new_sp_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i
);
  import intr_seq_pkg::*;

  localparam int STEP_W    = 3;
  localparam int SLOTS     = POP_BYTES;
  localparam int VEC_SHIFT = $clog2(VEC_BYTES);
  localparam logic [WORD_W-1:0] CLR_MASK =
    ~((WORD_W'(1) << IF_BIT) | (WORD_W'(1) << TF_BIT));

  seq_state_t state_q;
  logic [STEP_W-1:0] step_q;
  logic              entry_q;
  logic              busy_q;
  logic [WORD_W-1:0] sv_ip_q, sv_cs_q, sv_flags_q, ss_q, sp_w_q;
  logic [VEC_W-1:0]  vec_q;

  logic [WORD_W-1:0] stack_off;
  logic [ADDR_W-1:0] stack_addr;
  logic [ADDR_W-1:0] vec_addr;
  logic [BYTE_W-1:0] push_byte;
  logic              xfer;
  logic              last_step;
  logic              gath_we;
  logic [SLOTS-1:0][BYTE_W-1:0] gath;

  assign busy_q = (state_q != ST_IDLE);
  assign xfer   = mem_req_o && mem_rdy_i;

  always_comb begin
    unique case (state_q)
      ST_PUSH: last_step = (step_q == STEP_W'(PUSH_BYTES - 1));
      ST_VEC:  last_step = (step_q == STEP_W'(VEC_BYTES - 1));
      ST_POP:  last_step = (step_q == STEP_W'(POP_BYTES - 1));
      default: last_step = 1'b0;
    endcase
  end

  assign stack_off = (state_q == ST_POP) ? sp_w_q : (sp_w_q - WORD_W'(1));

  intr_seq_phys #(
    .SEG_W (WORD_W),
    .ADDR_W(ADDR_W),
    .SHIFT (SEG_SHIFT)
  ) u_phys (
    .seg_i (ss_q),
    .off_i (stack_off),
    .phys_o(stack_addr)
  );

  assign vec_addr = (ADDR_W'(vec_q) << VEC_SHIFT) + ADDR_W'(step_q);

  intr_seq_lane #(
    .BYTE_W(BYTE_W),
    .WORD_W(WORD_W),
    .STEP_W(STEP_W)
  ) u_lane (
    .step_i (step_q),
    .flags_i(sv_flags_q),
    .cs_i   (sv_cs_q),
    .ip_i   (sv_ip_q),
    .byte_o (push_byte)
  );

  assign gath_we = xfer && ((state_q == ST_VEC) || (state_q == ST_POP));

  intr_seq_gather #(
    .SLOTS (SLOTS),
    .BYTE_W(BYTE_W),
    .IDX_W (STEP_W)
  ) u_gather (
    .clk    (clk),
    .rst    (rst),
    .we_i   (gath_we),
    .idx_i  (step_q),
    .d_i    (mem_rdata_i),
    .slots_o(gath)
  );

  always_comb begin
    mem_req_o   = (state_q == ST_PUSH) || (state_q == ST_VEC) || (state_q == ST_POP);
    mem_we_o    = (state_q == ST_PUSH);
    mem_addr_o  = (state_q == ST_VEC) ? vec_addr : stack_addr;
    mem_wdata_o = (state_q == ST_PUSH) ? push_byte : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      entry_q     <= 1'b0;
      sv_ip_q     <= '0;
      sv_cs_q     <= '0;
      sv_flags_q  <= '0;
      ss_q        <= '0;
      sp_w_q      <= '0;
      vec_q       <= '0;
      new_ip_o    <= '0;
      new_cs_o    <= '0;
      new_flags_o <= '0;
      new_sp_o    <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          step_q <= '0;
          if (start_i) begin
            sv_ip_q    <= cur_ip_i;
            sv_cs_q    <= cur_cs_i;
            sv_flags_q <= cur_flags_i;
            ss_q       <= cur_ss_i;
            sp_w_q     <= cur_sp_i;
            vec_q      <= vec_i;
            entry_q    <= 1'b1;
            state_q    <= ST_PUSH;
          end else if (iret_i) begin
            ss_q    <= cur_ss_i;
            sp_w_q  <= cur_sp_i;
            entry_q <= 1'b0;
            state_q <= ST_POP;
          end
        end
        ST_PUSH: begin
          if (xfer) begin
            sp_w_q <= sp_w_q - WORD_W'(1);
            step_q <= last_step ? '0 : step_q + STEP_W'(1);
            if (last_step) state_q <= ST_VEC;
          end
        end
        ST_VEC: begin
          if (xfer) begin
            step_q <= last_step ? '0 : step_q + STEP_W'(1);
            if (last_step) state_q <= ST_FIN;
          end
        end
        ST_POP: begin
          if (xfer) begin
            sp_w_q <= sp_w_q + WORD_W'(1);
            step_q <= last_step ? '0 : step_q + STEP_W'(1);
            if (last_step) state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          new_ip_o <= {gath[1], gath[0]};
          new_cs_o <= {gath[3], gath[2]};
          new_sp_o <= sp_w_q;
          if (entry_q) new_flags_o <= sv_flags_q & CLR_MASK;
          else         new_flags_o <= {gath[5], gath[4]};
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 20,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              iret_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_rdy_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BYTE_W-1:0] mem_wdata_o,
  input logic              done_o,
  input logic [WORD_W-1:0] new_flags_o,
  input logic              busy_q,
  input logic              entry_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) rst |=> !mem_req_o && !done_o); // R1
  AST_WRITE_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_we_o |-> entry_q); // R2
  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (rst)
    done_o && entry_q |-> !new_flags_o[IF_BIT] && !new_flags_o[TF_BIT]); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(mem_req_o && mem_rdy_i, 2)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    busy_q && (start_i || iret_i) |=> $stable(entry_q)); // R8
endmodule

bind intr_seq intr_seq_chk #(
  .BYTE_W(BYTE_W),
  .WORD_W(WORD_W),
  .ADDR_W(ADDR_W),
  .IF_BIT(IF_BIT),
  .TF_BIT(TF_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .iret_i     (iret_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_rdy_i  (mem_rdy_i),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .done_o     (done_o),
  .new_flags_o(new_flags_o),
  .busy_q     (busy_q),
  .entry_q    (entry_q)
);

// File: tb/sim_intr_seq.sv
`timescale 1ns/1ps
module sim_intr_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, iret_i = 1'b0;
  logic [7:0]  vec_i = '0;
  logic [15:0] cur_ip_i = '0, cur_cs_i = '0, cur_flags_i = '0, cur_sp_i = '0, cur_ss_i = '0;
  logic [15:0] new_ip_o, new_cs_o, new_flags_o, new_sp_o;
  logic done_o, mem_req_o, mem_we_o;
  logic [19:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        mem_rdy_i = 1'b0;

  always #2 clk = ~clk;

  intr_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .vec_i(vec_i), .iret_i(iret_i),
    .cur_ip_i(cur_ip_i), .cur_cs_i(cur_cs_i), .cur_flags_i(cur_flags_i),
    .cur_sp_i(cur_sp_i), .cur_ss_i(cur_ss_i),
    .new_ip_o(new_ip_o), .new_cs_o(new_cs_o), .new_flags_o(new_flags_o),
    .new_sp_o(new_sp_o), .done_o(done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
  );

  typedef struct packed {
    logic [7:0]  vec;
    logic [15:0] ip, cs, fl, sp, ss;
    logic [3:0]  wt;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{8'h20, 16'h0055, 16'h1000, 16'h0302, 16'h0100, 16'h2000, 4'd0},
    '{8'h00, 16'h1234, 16'hABCD, 16'hFFFF, 16'h8000, 16'h0040, 4'd1},
    '{8'hFF, 16'hFFFE, 16'hF000, 16'h0000, 16'h0010, 16'h3000, 4'd2},
    '{8'h02, 16'h0A0B, 16'h0C0D, 16'h0246, 16'h0002, 16'hFFFF, 4'd3},
    '{8'h81, 16'h7F80, 16'h5555, 16'h0100, 16'h0000, 16'h0001, 4'd0},
    '{8'h03, 16'h0000, 16'h0000, 16'h0200, 16'hFFFE, 16'h1234, 4'd1}
  };

  logic [7:0] mem [int];
  int wt_cfg = 0;
  int wt_cnt = 0;
  int nchk = 0, nfail = 0;
  int wn = 0, rn = 0, pulses = 0;
  logic [19:0] wa [16];
  logic [7:0]  wd [16];
  logic [19:0] ra [16];

  function automatic logic [7:0] rd(input logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  function automatic logic [19:0] ph(input logic [15:0] s, input logic [15:0] o);
    logic [23:0] t;
    t = {4'h0, s, 4'h0} + {8'h00, o};
    return t[19:0];
  endfunction

  function automatic logic [15:0] isr_ip(input logic [7:0] v);
    return {v ^ 8'h5A, ~v};
  endfunction

  function automatic logic [15:0] isr_cs(input logic [7:0] v);
    return {v, v ^ 8'hC3};
  endfunction

  always @(negedge clk) begin
    mem_rdata_i = rd(mem_addr_o);
    if (mem_req_o) begin
      mem_rdy_i = (wt_cnt >= wt_cfg);
      wt_cnt = mem_rdy_i ? 0 : wt_cnt + 1;
    end else begin
      mem_rdy_i = 1'b0;
      wt_cnt = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst && mem_req_o && mem_rdy_i) begin
      if (mem_we_o) begin
        mem[int'(mem_addr_o)] = mem_wdata_o;
        if (wn < 16) begin wa[wn] = mem_addr_o; wd[wn] = mem_wdata_o; end
        wn++;
      end else begin
        if (rn < 16) ra[rn] = mem_addr_o;
        rn++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_vec(input logic [7:0] v);
    logic [15:0] i, c;
    i = isr_ip(v);
    c = isr_cs(v);
    mem[int'({v, 2'b00})]     = i[7:0];
    mem[int'({v, 2'b00}) + 1] = i[15:8];
    mem[int'({v, 2'b00}) + 2] = c[7:0];
    mem[int'({v, 2'b00}) + 3] = c[15:8];
  endtask

  task automatic run_op(input bit st, input bit it, input logic [7:0] v,
                        input logic [15:0] ip, cs, fl, sp, ss, input bit collide);
    wn = 0; rn = 0; pulses = 0;
    @(negedge clk);
    start_i = st; iret_i = it; vec_i = v;
    cur_ip_i = ip; cur_cs_i = cs; cur_flags_i = fl; cur_sp_i = sp; cur_ss_i = ss;
    @(negedge clk);
    start_i = 1'b0; iret_i = 1'b0;
    if (collide) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; iret_i = 1'b1; vec_i = 8'h81;
      cur_sp_i = 16'h4444; cur_ss_i = 16'h0500;
      @(negedge clk);
      start_i = 1'b0; iret_i = 1'b0;
    end
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done_o) pulses++;
      else if (pulses > 0) break;
    end
  endtask

  task automatic check_entry(input row_t r);
    logic [7:0] exp_b [6];
    exp_b = '{r.fl[15:8], r.fl[7:0], r.cs[15:8], r.cs[7:0], r.ip[15:8], r.ip[7:0]};
    chk(pulses == 1, "R7 done pulse count", pulses, 1);
    chk(wn == 6, "R2 push count", wn, 6);
    for (int k = 0; k < 6; k++) begin
      chk(wa[k] == ph(r.ss, r.sp - 16'(k + 1)), "R2/R9 push address", wa[k], ph(r.ss, r.sp - 16'(k + 1)));
      chk(wd[k] == exp_b[k], "R2 push byte order", wd[k], exp_b[k]);
    end
    chk(rn == 4, "R3 vector read count", rn, 4);
    for (int k = 0; k < 4; k++)
      chk(ra[k] == 20'({r.vec, 2'b00}) + 20'(k), "R3 vector address", ra[k], 20'({r.vec, 2'b00}) + 20'(k));
    chk(new_ip_o == isr_ip(r.vec), "R3 new IP", new_ip_o, isr_ip(r.vec));
    chk(new_cs_o == isr_cs(r.vec), "R3 new CS", new_cs_o, isr_cs(r.vec));
    chk(new_flags_o == (r.fl & 16'hFCFF), "R4 entry flags", new_flags_o, r.fl & 16'hFCFF);
    chk(new_sp_o == r.sp - 16'd6, "R4 entry SP", new_sp_o, r.sp - 16'd6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!mem_req_o && !done_o && !mem_we_o, "R1 reset control", {mem_req_o, done_o, mem_we_o}, 0);
    chk(new_ip_o == 0 && new_cs_o == 0 && new_flags_o == 0 && new_sp_o == 0,
        "R1 reset registers", {new_ip_o, new_sp_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req_o && !done_o, "R1 idle after reset", {mem_req_o, done_o}, 0);

    for (int i = 0; i < 6; i++) begin
      row_t r;
      logic [15:0] entry_sp;
      r = ROWS[i];
      wt_cfg = int'(r.wt);
      put_vec(r.vec);
      run_op(1'b1, 1'b0, r.vec, r.ip, r.cs, r.fl, r.sp, r.ss, 1'b0);
      check_entry(r);
      entry_sp = new_sp_o;
      run_op(1'b0, 1'b1, 8'h00, 16'h0, 16'h0, 16'h0, entry_sp, r.ss, 1'b0);
      chk(pulses == 1, "R7 return done pulse", pulses, 1);
      chk(wn == 0 && rn == 6, "R5 pop count", {wn[15:0], rn[15:0]}, 6);
      for (int k = 0; k < 6; k++)
        chk(ra[k] == ph(r.ss, entry_sp + 16'(k)), "R5/R9 pop address", ra[k], ph(r.ss, entry_sp + 16'(k)));
      chk(new_ip_o == r.ip, "R5 restored IP", new_ip_o, r.ip);
      chk(new_cs_o == r.cs, "R5 restored CS", new_cs_o, r.cs);
      chk(new_flags_o == r.fl, "R5 restored flags", new_flags_o, r.fl);
      chk(new_sp_o == r.sp, "R5/R9 restored SP", new_sp_o, r.sp);
      repeat (3) @(negedge clk);
      chk(new_ip_o == r.ip && !done_o, "R7 outputs hold", new_ip_o, r.ip);
    end

    // R8: strobes during a running entry are ignored
    wt_cfg = 1;
    put_vec(8'h20);
    put_vec(8'h81);
    run_op(1'b1, 1'b0, 8'h20, 16'h0055, 16'h1000, 16'h0302, 16'h0100, 16'h2000, 1'b1);
    check_entry(ROWS[0]);
    repeat (10) @(negedge clk);
    chk(!mem_req_o && !done_o, "R8 no extra access", {mem_req_o, done_o}, 0);

    // R10: start and return together in idle
    wt_cfg = 0;
    wn = 0;
    run_op(1'b1, 1'b1, 8'hFF, 16'hFFFE, 16'hF000, 16'h0000, 16'h0010, 16'h3000, 1'b0);
    chk(wn == 6, "R10 entry wins push count", wn, 6);
    chk(new_ip_o == isr_ip(8'hFF), "R10 entry wins new IP", new_ip_o, isr_ip(8'hFF));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule